// File: doc/BRIEF.md
# Armed Pulsed Discrete Command Controller

This block commands a bank of pulsed discrete outputs. Each output is meant to drive a latching relay that changes a power configuration. Commands arrive as single-cycle words on a valid-qualified bus. A channel fires only after two steps. First, an arm word must be accepted. Then the next command must be a fire word whose pattern names exactly one channel. After that, the selected output goes high for a fixed number of clock cycles. No other output can be active at the same time.

Any command that fails to match is refused. This includes near-miss codes, complementary codes, fires with no arm, a second arm, and anything received while a pulse is running. A refused command sets a sticky reject flag. Every command consumes the arm, so each pulse needs a fresh arm. An arm that is left unused expires after a parameterised number of cycles. Status outputs show whether the block is armed, whether a pulse is in progress, and which channel fired last.

Top module: `armed_pulse_ctrl`

## Requirements
- R1: There are NUM_CH (default 16) outputs. The fire word for channel n is {8'h96, n[3:0], ~n[3:0]}. Accepting it while armed drives pulseOut[n] high, starting on the clock edge that samples the command.
- R2: Each pulse lasts exactly PULSE_CYCLES clock cycles. The default of 5,000,000 gives 50 ms at 100 MHz.
- R3: At most one bit of pulseOut is ever high.
- R4: A fire word received while not armed produces no pulse and sets rejectFlag.
- R5: Only the exact word 16'h5AA5, received while idle, arms the block. Any other word received while idle leaves armed low and sets rejectFlag.
- R6: The command after an arm always clears armed, whether that command fires or is refused. A later fire word with no new arm produces no pulse.
- R7: While armed, any word that is not a valid fire word produces no pulse and sets rejectFlag. This covers a check nibble that is not the complement, a bitwise-complemented fire word, a tag with one bit wrong, and a repeated arm.
- R8: Commands received while busy are refused and set rejectFlag. They do not change, extend or retrigger the running pulse.
- R9: An arm with no following command stays armed for ARM_TIMEOUT cycles and then returns to idle without setting rejectFlag.
- R10: rejectFlag stays set until clrReject is asserted. If a new reject arrives in the same cycle as clrReject, the flag stays set.
- R11: lastChan holds the index of the most recently fired channel. Refused commands leave it unchanged.
- R12: After reset, pulseOut, armed, busy, lastChan and rejectFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word is valid this cycle |
| cmdWord | input | CMD_W (16) | Command word |
| clrReject | input | 1 | Clears the sticky reject flag |
| pulseOut | output | NUM_CH (16) | Pulsed discrete outputs, at most one high |
| armed | output | 1 | An arm is pending |
| busy | output | 1 | A pulse is in progress |
| lastChan | output | $clog2(NUM_CH) (4) | Index of the last fired channel |
| rejectFlag | output | 1 | Sticky flag for refused commands |

## Verification
The fire path is exercised at both extreme channel indices and at two mid-range indices whose codes are bitwise inverses of each other. This shows that the decoder picks the channel from its index field and not from some other bit pattern.

The negative cases cover several distinct failures. A word whose check nibble repeats the index is refused, which shows that the complement check is actually enforced. A fully inverted fire word, a tag with one bit flipped, an index paired with a wrong check nibble, and an arm word sent in the fire slot each test a different comparison. An arm word that is off by one bit, and an arm word that is fully inverted, show that arming needs an exact match.

Directed sequences also cover several timing behaviours. One shows that a refused fire consumes the arm. Others send commands in the middle of a pulse, run the arm timeout to the exact cycle it ends, and assert a reject and a clear in the same cycle.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PULSE = 2'd2
  } apcState_t;

  typedef struct packed {
    logic armLoad;
    logic fireStart;
    logic rejectSet;
  } apcStrobe_t;

endpackage

// File: rtl/apc_control.sv
module apc_control
  import apc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       isArm,
  input  logic       fireHit,
  input  logic       pulseDone,
  input  logic       timeoutHit,
  output apcStrobe_t strobe,
  output logic       armed,
  output logic       busy
);

  apcState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          if (isArm) begin
            stateNext      = ST_ARMED;
            strobe.armLoad = 1'b1;
          end else begin
            strobe.rejectSet = 1'b1;
          end
        end
      end
      ST_ARMED: begin
        if (cmdValid) begin
          if (fireHit) begin
            stateNext        = ST_PULSE;
            strobe.fireStart = 1'b1;
          end else begin
            stateNext        = ST_IDLE;
            strobe.rejectSet = 1'b1;
          end
        end else if (timeoutHit) begin
          stateNext = ST_IDLE;
        end
      end
      ST_PULSE: begin
        if (cmdValid) strobe.rejectSet = 1'b1;
        if (pulseDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign armed = (state == ST_ARMED);
  assign busy  = (state == ST_PULSE);

endmodule

// File: rtl/apc_datapath.sv
module apc_datapath
  import apc_pkg::*;
#(
  parameter int                NUM_CH       = 16,
  parameter int                CMD_W        = 16,
  parameter int                PULSE_CYCLES = 5_000_000,
  parameter int                ARM_TIMEOUT  = 1_000_000,
  parameter logic [CMD_W-1:0]  ARM_CODE     = 16'h5AA5,
  parameter int                CH_W         = $clog2(NUM_CH),
  parameter logic [CMD_W-2*CH_W-1:0] FIRE_TAG = 8'h96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  apcStrobe_t        strobe,
  input  logic              clrReject,
  output logic              isArm,
  output logic              fireHit,
  output logic              pulseDone,
  output logic              timeoutHit,
  output logic [NUM_CH-1:0] pulseOut,
  output logic [CH_W-1:0]   lastChan,
  output logic              rejectFlag
);

  localparam int TAG_W   = CMD_W - 2 * CH_W;
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam int TO_W    = $clog2(ARM_TIMEOUT + 1);

  logic [TAG_W-1:0]   cmdTag;
  logic [CH_W-1:0]    cmdIdx;
  logic [CH_W-1:0]    cmdCheck;
  logic               idxInRange;
  logic [NUM_CH-1:0]  selVec;
  logic [PULSE_W-1:0] pulseCnt;
  logic [TO_W-1:0]    armCnt;

  assign cmdTag   = cmdWord[CMD_W-1 -: TAG_W];
  assign cmdIdx   = cmdWord[2*CH_W-1 -: CH_W];
  assign cmdCheck = cmdWord[CH_W-1:0];

  generate
    if (NUM_CH == (1 << CH_W)) begin : g_fullRange
      assign idxInRange = 1'b1;
    end else begin : g_partRange
      assign idxInRange = ({1'b0, cmdIdx} < (CH_W+1)'(NUM_CH));
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign selVec[i] = (cmdIdx == CH_W'(i));
    end
  endgenerate

  assign isArm   = (cmdWord == ARM_CODE);
  assign fireHit = (cmdTag == FIRE_TAG) && (cmdCheck == ~cmdIdx) && idxInRange;

  assign pulseDone  = (|pulseOut) && (pulseCnt == '0);
  assign timeoutHit = (armCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOut <= '0;
      pulseCnt <= '0;
    end else if (strobe.fireStart) begin
      pulseOut <= selVec;
      pulseCnt <= PULSE_W'(PULSE_CYCLES - 1);
    end else if (|pulseOut) begin
      if (pulseCnt == '0) pulseOut <= '0;
      else                pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                armCnt <= '0;
    else if (strobe.armLoad)  armCnt <= TO_W'(ARM_TIMEOUT - 1);
    else if (armCnt != '0)    armCnt <= armCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 lastChan <= '0;
    else if (strobe.fireStart) lastChan <= cmdIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rejectFlag <= 1'b0;
    else if (strobe.rejectSet) rejectFlag <= 1'b1;
    else if (clrReject)        rejectFlag <= 1'b0;
  end

endmodule

// File: rtl/armed_pulse_ctrl.sv
module armed_pulse_ctrl
  import apc_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int CMD_W        = 16,
  parameter int PULSE_CYCLES = 5_000_000,
  parameter int ARM_TIMEOUT  = 1_000_000,
  parameter int CH_W         = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              clrReject,
  output logic [NUM_CH-1:0] pulseOut,
  output logic              armed,
  output logic              busy,
  output logic [CH_W-1:0]   lastChan,
  output logic              rejectFlag
);

  apcStrobe_t strobe;
  logic       isArm;
  logic       fireHit;
  logic       pulseDone;
  logic       timeoutHit;

  apc_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .isArm      (isArm),
    .fireHit    (fireHit),
    .pulseDone  (pulseDone),
    .timeoutHit (timeoutHit),
    .strobe     (strobe),
    .armed      (armed),
    .busy       (busy)
  );

  apc_datapath #(
    .NUM_CH       (NUM_CH),
    .CMD_W        (CMD_W),
    .PULSE_CYCLES (PULSE_CYCLES),
    .ARM_TIMEOUT  (ARM_TIMEOUT),
    .CH_W         (CH_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdWord    (cmdWord),
    .strobe     (strobe),
    .clrReject  (clrReject),
    .isArm      (isArm),
    .fireHit    (fireHit),
    .pulseDone  (pulseDone),
    .timeoutHit (timeoutHit),
    .pulseOut   (pulseOut),
    .lastChan   (lastChan),
    .rejectFlag (rejectFlag)
  );

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int NUM_CH       = 16,
  parameter int PULSE_CYCLES = 5_000_000
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              clrReject,
  input logic [NUM_CH-1:0] pulseOut,
  input logic              armed,
  input logic              busy,
  input logic              rejectFlag
);

  logic [31:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          hiCnt <= '0;
    else if (|pulseOut) hiCnt <= hiCnt + 1'b1;
    else                hiCnt <= '0;
  end

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseOut)); // R3

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|pulseOut) |-> (hiCnt == 32'(PULSE_CYCLES))); // R2

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|pulseOut) |-> $past(armed)); // R4

  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cmdValid) |=> !armed); // R6

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseOut) |=> ((pulseOut == $past(pulseOut)) || (pulseOut == '0))); // R8

  AST_BUSY_CMD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> rejectFlag); // R8

  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rejectFlag && !clrReject) |=> rejectFlag); // R10

  AST_ARM_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(armed && busy)); // R9

endmodule

bind armed_pulse_ctrl apc_checker #(
  .NUM_CH       (NUM_CH),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_apc_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .clrReject  (clrReject),
  .pulseOut   (pulseOut),
  .armed      (armed),
  .busy       (busy),
  .rejectFlag (rejectFlag)
);

// File: tb/armed_pulse_ctrl_tb_top.sv
module armed_pulse_ctrl_tb_top;

  localparam int NUM_CH   = 16;
  localparam int CMD_W    = 16;
  localparam int PULSE    = 20;
  localparam int TIMEOUT  = 30;
  localparam logic [15:0] ARMW = 16'h5AA5;
  localparam int NVEC = 12;

  // vector: {doArm, word[15:0], expFire, expCh[3:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 16'h960F, 1'b1, 4'd0},
    {1'b1, 16'h96F0, 1'b1, 4'd15},
    {1'b1, 16'h965A, 1'b1, 4'd5},
    {1'b1, 16'h96A5, 1'b1, 4'd10},
    {1'b1, 16'h9655, 1'b0, 4'd0},
    {1'b1, 16'h69A5, 1'b0, 4'd0},
    {1'b1, 16'h975A, 1'b0, 4'd0},
    {1'b1, 16'h9679, 1'b0, 4'd0},
    {1'b0, 16'h963C, 1'b0, 4'd0},
    {1'b1, 16'h963C, 1'b1, 4'd3},
    {1'b1, 16'h5AA5, 1'b0, 4'd0},
    {1'b0, 16'h0000, 1'b0, 4'd0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [CMD_W-1:0]  cmdWord = '0;
  logic              clrReject = 1'b0;
  logic [NUM_CH-1:0] pulseOut;
  logic              armed;
  logic              busy;
  logic [3:0]        lastChan;
  logic              rejectFlag;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  armed_pulse_ctrl #(
    .NUM_CH       (NUM_CH),
    .CMD_W        (CMD_W),
    .PULSE_CYCLES (PULSE),
    .ARM_TIMEOUT  (TIMEOUT)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdWord    (cmdWord),
    .clrReject  (clrReject),
    .pulseOut   (pulseOut),
    .armed      (armed),
    .busy       (busy),
    .lastChan   (lastChan),
    .rejectFlag (rejectFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [15:0] w);
    cmdValid = 1'b1;
    cmdWord  = w;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord  = '0;
  endtask

  task automatic clearRej();
    clrReject = 1'b1;
    @(negedge clk);
    clrReject = 1'b0;
  endtask

  task automatic measureWidth(output int n);
    n = 0;
    while ((|pulseOut) && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(pulseOut == '0 && !armed && !busy && lastChan == 0 && !rejectFlag, "R12 reset",
        {pulseOut, armed, busy, lastChan, rejectFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector walk: R1 R2 R3 R4 R7
    for (int v = 0; v < NVEC; v++) begin
      logic        doArm;
      logic [15:0] word;
      logic        expFire;
      logic [3:0]  expCh;
      logic [3:0]  prevCh;
      {doArm, word, expFire, expCh} = VEC[v];
      clearRej();
      prevCh = lastChan;
      if (doArm) begin
        sendCmd(ARMW);
        chk(armed, "R5 arm accepted", armed, 1);
      end
      sendCmd(word);
      chk(!armed, "R6 arm consumed", armed, 0);
      if (expFire) begin
        chk(pulseOut == (16'b1 << expCh), "R1/R3 channel select", pulseOut, 16'b1 << expCh);
        chk(!rejectFlag, "R1 no reject on valid fire", rejectFlag, 0);
        chk(lastChan == expCh, "R11 last channel", lastChan, expCh);
        measureWidth(w);
        chk(w == PULSE, "R2 pulse width", w, PULSE);
      end else begin
        chk(pulseOut == '0, "R4/R7 refused word no pulse", pulseOut, 0);
        chk(rejectFlag, "R4/R7 reject set", rejectFlag, 1);
        chk(lastChan == prevCh, "R11 unchanged on reject", lastChan, prevCh);
      end
      @(negedge clk);
    end

    // R5 near-miss and complement arm words
    clearRej();
    sendCmd(16'h5AA4);
    chk(!armed && rejectFlag, "R5 near-miss arm", {armed, rejectFlag}, 2'b01);
    clearRej();
    sendCmd(16'hA55A);
    chk(!armed && rejectFlag, "R5 complement arm", {armed, rejectFlag}, 2'b01);

    // R6 refused fire consumes arm; later good fire is refused
    clearRej();
    sendCmd(ARMW);
    sendCmd(16'h9612);
    sendCmd(16'h9678);
    chk(pulseOut == '0, "R6 fire after consumed arm", pulseOut, 0);

    // R8 commands during pulse
    clearRej();
    sendCmd(ARMW);
    sendCmd(16'h9678);
    chk(pulseOut == 16'h0080, "R8 fire ch7", pulseOut, 16'h0080);
    sendCmd(ARMW);
    chk(!armed && rejectFlag, "R8 arm during pulse", {armed, rejectFlag}, 2'b01);
    sendCmd(16'h963C);
    chk(pulseOut == 16'h0080 && lastChan == 7, "R8 no retrigger", {pulseOut, lastChan}, {16'h0080, 4'd7});
    measureWidth(w);
    chk(w == PULSE - 2, "R8 pulse not extended", w, PULSE - 2);

    // R9 arm timeout
    clearRej();
    sendCmd(ARMW);
    repeat (TIMEOUT - 1) @(negedge clk);
    chk(armed, "R9 armed before expiry", armed, 1);
    @(negedge clk);
    chk(!armed && !rejectFlag, "R9 expired without reject", {armed, rejectFlag}, 0);
    sendCmd(16'h965A);
    chk(pulseOut == '0 && rejectFlag, "R9 fire after expiry", {pulseOut, rejectFlag}, 1);

    // R10 sticky and clear
    @(negedge clk);
    chk(rejectFlag, "R10 sticky", rejectFlag, 1);
    clearRej();
    chk(!rejectFlag, "R10 cleared", rejectFlag, 0);
    clrReject = 1'b1;
    sendCmd(16'h1234);
    clrReject = 1'b0;
    chk(rejectFlag, "R10 set wins over clear", rejectFlag, 1);

    finishRun();
  end

endmodule